// File: doc/BRIEF.md
# Serial EEPROM Page Write Sequencer

This block writes a run of 16-bit words into a serial EEPROM over a four-wire SPI link (active-low chip select, clock, data to the device, data from the device). A client pulses `start_i` with a word offset and a word count. The block checks the range first. It then fetches each word through a simple fetch port and reports a one-cycle `done_o` or `err_o` at the end.

The run is cut into bursts, and no burst crosses a device page. Each burst has the same steps in the same order. The block requests the shared bus and waits for a grant. It polls the device status until the ready bit reads clear. It sends a write-enable command as a frame of its own. It then sends the write command, the byte address and the byte-swapped data words. After the last word of the burst it raises chip select, waits out the device write time, and drops the bus request before the next burst begins.

Top module: `eeprom_page_writer`

## Requirements
- R1: A start is rejected with a one-cycle `err_o` and no bus request if the offset is WORDS or more, if the count is zero, or if the count exceeds WORDS minus the offset. A run that ends exactly on the last word is accepted.
- R2: After reset all outputs are idle: `busy_o`, `req_o`, clock, data line, `done_o` and `err_o` are low, and chip select is high. `busy_o` rises the cycle after an accepted start and falls in the same cycle that `done_o` or `err_o` pulses. Start pulses while busy are ignored.
- R3: Chip select goes low only while `req_o` is high. If `gnt_i` has not arrived after GRANT_TRIES cycles of request, `req_o` drops and `err_o` pulses.
- R4: Each burst begins with status frames. A frame is opcode 0x05 followed by 8 bits read from the device. A frame whose last status bit (bit 0) is 1 is followed by a chip-select pulse and a new frame. After READY_TRIES busy frames the block raises chip select, drops `req_o` and pulses `err_o`.
- R5: Every write frame is preceded by a frame holding only the write-enable opcode 0x06.
- R6: The write opcode is 0x02. When ADDR_W is 8 and the burst's first word index is 128 or more, bit 3 (0x08) is also set and carries the ninth byte-address bit.
- R7: After the opcode, the byte address (twice the word index) is sent in ADDR_W bits.
- R8: Each data word is sent as 16 bits with its two bytes exchanged (low byte first), each byte most significant bit first, so the device stores exactly the fetched word.
- R9: A burst ends after the word whose next byte address is a multiple of PAGE_BYTES, or after the last word. No burst spans two pages. Between bursts, chip select stays high for at least WRITE_WAIT cycles and `req_o` goes low.
- R10: Each bit is placed on the data line one cycle before a single-cycle clock high. The data line holds steady while the clock is high and is low when chip select rises.
- R11: `done_o` pulses once after the last burst's bus release, and the device then holds every requested word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a write run |
| offset_i | input | OW | First word index |
| count_i | input | OW | Number of words |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: run completed |
| err_o | output | 1 | One-cycle pulse: run rejected or aborted |
| fetch_o | output | 1 | Data word is sampled this cycle |
| fetch_addr_o | output | IW | Word index being fetched |
| fetch_data_i | input | 16 | Word for `fetch_addr_o`, valid while `fetch_o` is high |
| req_o | output | 1 | Bus request to the external arbiter |
| gnt_i | input | 1 | Bus grant |
| spi_cs_n_o | output | 1 | Device chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
Runs are tried at a mid-array offset that spans four bursts, including single-word bursts at both ends. This separates page splitting from plain counting. A run crossing word 128 shows whether the ninth address bit is folded into the opcode for the upper half only. A run ending on the last word, and rejected runs just past it, bracket the range check. Busy status reads (a few, then endless) and a grant that never comes exercise the retry and abort paths. The word pattern has distinct bytes, so a missing or doubled byte swap shows up in the device-side memory.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_REQ, ST_PREP, ST_POLL_OP, ST_POLL_IN, ST_GAP,
        ST_WREN, ST_WROP, ST_ADDR, ST_DATA, ST_WAIT, ST_REL
    } pw_state_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_HIGH, PH_LOW
    } sh_phase_e;

    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_WRITE  = 8'h02;
    localparam logic [7:0] OPC_HIADDR = 8'h08;

endpackage

// File: rtl/eeprom_cmd_check.sv
module eeprom_cmd_check #(
    parameter int WORDS = 256,
    parameter int OW    = 9
) (
    input  logic [OW-1:0] offset_i,
    input  logic [OW-1:0] count_i,
    output logic          bad_o
);
    logic [OW:0] room;
    logic [OW:0] limit;

    assign limit = (OW+1)'(WORDS);
    assign room  = limit - {1'b0, offset_i};
    assign bad_o = ({1'b0, offset_i} >= limit) || (count_i == '0) ||
                   ({1'b0, count_i} > room);
endmodule

// File: rtl/eeprom_bit_shifter.sv
module eeprom_bit_shifter
    import eeprom_pw_pkg::*;
#(
    parameter int MAXB = 16,
    localparam int CW = $clog2(MAXB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CW-1:0]   nbits_i,
    input  logic [MAXB-1:0] data_i,
    input  logic            miso_i,
    output logic            sck_o,
    output logic            mosi_o,
    output logic            done_o,
    output logic            last_o
);
    typedef struct packed {
        sh_phase_e       ph;
        logic [MAXB-1:0] sh;
        logic [CW-1:0]   cnt;
        logic            last;
    } sh_t;

    localparam sh_t SH_RST = '{ph: PH_IDLE, sh: '0, cnt: '0, last: 1'b0};

    sh_t q, n;

    always_comb begin
        n = q;
        case (q.ph)
            PH_IDLE: if (start_i) begin
                n.sh  = data_i << (CW'(MAXB) - nbits_i);
                n.cnt = nbits_i;
                n.ph  = PH_SETUP;
            end
            PH_SETUP: n.ph = PH_HIGH;
            PH_HIGH: begin
                n.last = miso_i;
                n.ph   = PH_LOW;
            end
            PH_LOW: begin
                if (q.cnt == CW'(1)) begin
                    n.ph = PH_IDLE;
                    n.sh = '0;
                end else begin
                    n.sh  = q.sh << 1;
                    n.cnt = q.cnt - 1'b1;
                    n.ph  = PH_SETUP;
                end
            end
            default: n.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SH_RST;
        else        q <= n;
    end

    assign sck_o  = (q.ph == PH_HIGH);
    assign mosi_o = (q.ph != PH_IDLE) && q.sh[MAXB-1];
    assign done_o = (q.ph == PH_LOW) && (q.cnt == CW'(1));
    assign last_o = q.last;

    // R10: data line is steady across the clock-high cycle
    a_r10_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> $stable(mosi_o));
    // R10: clock high lasts exactly one cycle
    a_r10_sck_single: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |=> !sck_o);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int WORDS       = 256,
    parameter int OP_W        = 8,
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 8,
    parameter int GRANT_TRIES = 8,
    parameter int READY_TRIES = 4,
    parameter int WRITE_WAIT  = 20,
    localparam int IW = $clog2(WORDS),
    localparam int OW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [OW-1:0] offset_i,
    input  logic [OW-1:0] count_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          fetch_o,
    output logic [IW-1:0] fetch_addr_o,
    input  logic [15:0]   fetch_data_i,
    output logic          req_o,
    input  logic          gnt_i,
    output logic          spi_cs_n_o,
    output logic          spi_sck_o,
    output logic          spi_mosi_o,
    input  logic          spi_miso_i
);
    localparam int PAGE_WORDS = PAGE_BYTES / 2;
    localparam int PW         = $clog2(PAGE_WORDS);
    localparam int TW         = $clog2(GRANT_TRIES + READY_TRIES + WRITE_WAIT + 1);
    localparam int SB         = 16;
    localparam int CW         = $clog2(SB + 1);
    localparam bit HI_FOLD    = (ADDR_W == 8);

    typedef struct packed {
        pw_state_e     st;
        pw_state_e     ret;
        logic          go;
        logic          cs_n;
        logic          req;
        logic          done;
        logic          err;
        logic [IW-1:0] idx;
        logic [OW-1:0] left;
        logic [TW-1:0] tmr;
    } pw_t;

    localparam pw_t PW_RST = '{st: ST_IDLE, ret: ST_IDLE, go: 1'b0, cs_n: 1'b1,
                               req: 1'b0, done: 1'b0, err: 1'b0, idx: '0,
                               left: '0, tmr: '0};

    pw_t q, n;

    logic          cmd_bad;
    logic          sh_done;
    logic          sh_last;
    logic [CW-1:0] sh_bits;
    logic [SB-1:0] sh_data;
    logic [IW-1:0] idx_nx;
    logic [IW:0]   byte_addr;
    logic          hi_half;
    logic          page_end;

    eeprom_cmd_check #(.WORDS(WORDS), .OW(OW)) u_check (
        .offset_i (offset_i),
        .count_i  (count_i),
        .bad_o    (cmd_bad)
    );

    eeprom_bit_shifter #(.MAXB(SB)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.go),
        .nbits_i (sh_bits),
        .data_i  (sh_data),
        .miso_i  (spi_miso_i),
        .sck_o   (spi_sck_o),
        .mosi_o  (spi_mosi_o),
        .done_o  (sh_done),
        .last_o  (sh_last)
    );

    assign idx_nx    = q.idx + 1'b1;
    assign byte_addr = {q.idx, 1'b0};
    assign hi_half   = HI_FOLD && (int'(q.idx) >= 128);

    generate
        if (PAGE_WORDS <= 1) begin : g_page_one
            assign page_end = 1'b1;
        end else begin : g_page_many
            assign page_end = (idx_nx[PW-1:0] == '0);
        end
    endgenerate

    // Frame content for the shifter, chosen by the sequencer state
    always_comb begin
        sh_bits = CW'(OP_W);
        sh_data = '0;
        case (q.st)
            ST_POLL_OP: sh_data = SB'(OPC_RDSR);
            ST_POLL_IN: sh_bits = CW'(8);
            ST_WREN:    sh_data = SB'(OPC_WREN);
            ST_WROP:    sh_data = SB'(OPC_WRITE | (hi_half ? OPC_HIADDR : 8'h00));
            ST_ADDR: begin
                sh_bits = CW'(ADDR_W);
                sh_data = SB'(byte_addr);
            end
            ST_DATA: begin
                sh_bits = CW'(SB);
                sh_data = {fetch_data_i[7:0], fetch_data_i[15:8]};
            end
            default: ;
        endcase
    end

    always_comb begin
        n      = q;
        n.go   = 1'b0;
        n.done = 1'b0;
        n.err  = 1'b0;
        case (q.st)
            ST_IDLE: if (start_i) begin
                if (cmd_bad) begin
                    n.err = 1'b1;
                end else begin
                    n.st   = ST_REQ;
                    n.req  = 1'b1;
                    n.idx  = offset_i[IW-1:0];
                    n.left = count_i;
                    n.tmr  = '0;
                end
            end
            ST_REQ: begin
                if (gnt_i) begin
                    n.st   = ST_PREP;
                    n.cs_n = 1'b0;
                    n.tmr  = '0;
                end else if (q.tmr == TW'(GRANT_TRIES - 1)) begin
                    n.st  = ST_IDLE;
                    n.req = 1'b0;
                    n.err = 1'b1;
                end else begin
                    n.tmr = q.tmr + 1'b1;
                end
            end
            ST_PREP: begin
                n.st = ST_POLL_OP;
                n.go = 1'b1;
            end
            ST_POLL_OP: if (sh_done) begin
                n.st = ST_POLL_IN;
                n.go = 1'b1;
            end
            ST_POLL_IN: if (sh_done) begin
                n.cs_n = 1'b1;
                if (!sh_last) begin
                    n.st  = ST_GAP;
                    n.ret = ST_WREN;
                end else if (q.tmr == TW'(READY_TRIES - 1)) begin
                    n.st  = ST_IDLE;
                    n.req = 1'b0;
                    n.err = 1'b1;
                end else begin
                    n.st  = ST_GAP;
                    n.ret = ST_POLL_OP;
                    n.tmr = q.tmr + 1'b1;
                end
            end
            ST_GAP: begin
                n.st   = q.ret;
                n.cs_n = 1'b0;
                n.go   = 1'b1;
            end
            ST_WREN: if (sh_done) begin
                n.st   = ST_GAP;
                n.ret  = ST_WROP;
                n.cs_n = 1'b1;
            end
            ST_WROP: if (sh_done) begin
                n.st = ST_ADDR;
                n.go = 1'b1;
            end
            ST_ADDR: if (sh_done) begin
                n.st = ST_DATA;
                n.go = 1'b1;
            end
            ST_DATA: if (sh_done) begin
                n.idx  = idx_nx;
                n.left = q.left - 1'b1;
                if (q.left == OW'(1) || page_end) begin
                    n.st   = ST_WAIT;
                    n.cs_n = 1'b1;
                    n.tmr  = '0;
                end else begin
                    n.go = 1'b1;
                end
            end
            ST_WAIT: begin
                if (q.tmr == TW'(WRITE_WAIT - 1)) begin
                    n.st  = ST_REL;
                    n.req = 1'b0;
                end else begin
                    n.tmr = q.tmr + 1'b1;
                end
            end
            ST_REL: begin
                if (q.left == '0) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                end else begin
                    n.st  = ST_REQ;
                    n.req = 1'b1;
                    n.tmr = '0;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= PW_RST;
        else        q <= n;
    end

    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = q.done;
    assign err_o        = q.err;
    assign req_o        = q.req;
    assign spi_cs_n_o   = q.cs_n;
    assign fetch_o      = q.go && (q.st == ST_DATA);
    assign fetch_addr_o = q.idx;

    // R1: a bad range is refused at once without going busy
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cmd_bad) |=> (err_o && !busy_o));
    // R2: busy only ends together with an outcome pulse
    a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o || err_o));
    // R3: the device is selected only while the bus is requested
    a_r3_cs_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n_o |-> req_o);
    // R9: no serial clock while the device is deselected
    a_r9_sck_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sck_o);
endmodule

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
    localparam int WORDS       = 256;
    localparam int PAGE_WORDS  = 4;
    localparam int READY_TRIES = 4;
    localparam int WRITE_WAIT  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] offset_i = '0;
    logic [8:0] count_i = '0;
    logic       busy_o, done_o, err_o, fetch_o, req_o;
    logic [7:0] fetch_addr_o;
    logic [15:0] fetch_data_i;
    logic       gnt_i = 1'b0;
    logic       spi_cs_n_o, spi_sck_o, spi_mosi_o;
    logic       spi_miso_i = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] pat(logic [7:0] a);
        return {a ^ 8'h5A, (~a) + 8'h31};
    endfunction

    assign fetch_data_i = pat(fetch_addr_o);

    eeprom_page_writer u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
        .count_i(count_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .fetch_o(fetch_o), .fetch_addr_o(fetch_addr_o), .fetch_data_i(fetch_data_i),
        .req_o(req_o), .gnt_i(gnt_i), .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o),
        .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Behavioural device and arbiter model
    logic [15:0] mem [0:WORDS-1];
    logic [15:0] exp_mem [0:WORDS-1];
    logic        bits [0:255];
    int  nb = 0;
    bit  wren = 0;
    int  busy_left = 0;
    bit  busy_forever = 0;
    bit  gnt_never = 0;
    int  gnt_dly = 2;
    int  req_cnt = 0;
    int  cyc = 0;
    int  last_wr_end = 0;
    bit  gap_pending = 0;
    bit  req_low_seen = 0;
    int  n_wframes = 0, n_status = 0, n_a8 = 0, n_req_rise = 0;
    bit  prev_cs = 1, prev_sck = 0, prev_req = 0;

    task automatic finish_frame();
        logic [7:0]  op;
        logic [15:0] raw;
        int ba, w, k;
        op = '0;
        for (int i = 0; i < 8; i++) op = {op[6:0], bits[i]};
        if (nb == 8 && op == 8'h06) begin
            wren = 1;
        end else if (op == 8'h05) begin
            check(nb == 16, "R4", "status frame length", nb, 16);
            n_status++;
            if (busy_left > 0) busy_left--;
            wren = 0;
        end else if ((op & 8'hF7) == 8'h02 && nb >= 32 && ((nb - 16) % 16) == 0) begin
            k  = (nb - 16) / 16;
            ba = op[3] ? 256 : 0;
            for (int i = 8; i < 16; i++) ba = ba + (int'(bits[i]) << (15 - i));
            check(wren, "R5", "write-enable frame before write", int'(wren), 1);
            check(ba % 2 == 0, "R7", "byte address even", ba % 2, 0);
            w = ba / 2;
            check((w % PAGE_WORDS) + k <= PAGE_WORDS, "R9", "burst within one page",
                  (w % PAGE_WORDS) + k, PAGE_WORDS);
            check(op[3] == (w >= 128), "R6", "high address bit in opcode",
                  int'(op[3]), int'(w >= 128));
            if (op[3]) n_a8++;
            for (int j = 0; j < k; j++) begin
                raw = '0;
                for (int b = 0; b < 16; b++) raw = {raw[14:0], bits[16 + 16*j + b]};
                mem[(w + j) % WORDS] = {raw[7:0], raw[15:8]};
            end
            wren = 0;
            n_wframes++;
            last_wr_end = cyc;
            gap_pending = 1;
            req_low_seen = 0;
        end else begin
            check(0, "R5", "recognised frame opcode", int'(op), -1);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_cs = 1; prev_sck = 0; prev_req = 0;
            gnt_i = 0; req_cnt = 0; spi_miso_i = 0;
        end else begin
            if (req_o && !prev_req) n_req_rise++;
            if (req_o && !gnt_never) begin
                req_cnt++;
                gnt_i = (req_cnt > gnt_dly);
            end else begin
                req_cnt = 0;
                gnt_i = 0;
            end
            if (!req_o) req_low_seen = 1;
            if (prev_cs && !spi_cs_n_o) begin
                nb = 0;
                if (gap_pending) begin
                    check(((cyc - last_wr_end) >= WRITE_WAIT) && req_low_seen, "R9",
                          "write-time gap and release before next burst",
                          cyc - last_wr_end, WRITE_WAIT);
                    gap_pending = 0;
                end
            end
            if (!spi_cs_n_o && spi_sck_o && !prev_sck && nb < 256) begin
                bits[nb] = spi_mosi_o;
                nb++;
            end
            if (!prev_cs && spi_cs_n_o) begin
                check(spi_mosi_o == 1'b0, "R10", "data line low at frame end",
                      int'(spi_mosi_o), 0);
                finish_frame();
            end
            spi_miso_i = busy_forever || (busy_left > 0);
            prev_cs = spi_cs_n_o; prev_sck = spi_sck_o; prev_req = req_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog expired: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    task automatic run(input int off, input int cnt, input int poke,
                       output bit gd, output bit ge, output bit b1);
        start_i  = 1'b1;
        offset_i = 9'(off);
        count_i  = 9'(cnt);
        @(negedge clk);
        start_i = 1'b0;
        b1 = busy_o;
        gd = 0;
        ge = 0;
        for (int i = 0; i < 30000; i++) begin
            if (done_o) gd = 1;
            if (err_o) ge = 1;
            if (gd || ge) break;
            if (i == poke) begin
                start_i  = 1'b1;
                offset_i = 9'd200;
                count_i  = 9'd1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_words(input int off, input int cnt);
        for (int i = 0; i < cnt; i++) exp_mem[off + i] = pat(8'(off + i));
    endtask

    task automatic compare_mem(input string req, input string what);
        int bad = 0;
        for (int i = 0; i < WORDS; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, req, what, bad, 0);
    endtask

    initial begin
        bit gd, ge, b1;
        int wf0, st0, a80, rr0;
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        check(!busy_o && !req_o && spi_cs_n_o && !spi_sck_o && !spi_mosi_o && !done_o && !err_o,
              "R2", "idle outputs in reset",
              int'({busy_o, req_o, spi_cs_n_o, spi_sck_o, spi_mosi_o, done_o, err_o}), 16);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Run over four bursts; a start poked while busy must be ignored
        wf0 = n_wframes; st0 = n_status;
        run(3, 10, 60, gd, ge, b1);
        expect_words(3, 10);
        check(b1, "R2", "busy after accepted start", int'(b1), 1);
        check(gd && !ge, "R11", "done for run 3..12", int'({gd, ge}), 2);
        check(n_wframes - wf0 == 4, "R9", "bursts for run 3..12", n_wframes - wf0, 4);
        check(n_status - st0 == 4, "R4", "one ready poll per burst", n_status - st0, 4);
        compare_mem("R8", "memory after run 3..12 (word 200 untouched, R2)");

        // Run across word 128 with two busy status reads
        busy_left = 2;
        wf0 = n_wframes; st0 = n_status; a80 = n_a8;
        run(126, 5, -1, gd, ge, b1);
        expect_words(126, 5);
        check(gd && !ge, "R11", "done for run 126..130", int'({gd, ge}), 2);
        check(n_status - st0 == 4, "R4", "busy polls repeated", n_status - st0, 4);
        check(n_a8 - a80 == 1, "R6", "upper-half write frames", n_a8 - a80, 1);
        check(n_wframes - wf0 == 2, "R9", "bursts for run 126..130", n_wframes - wf0, 2);
        compare_mem("R8", "memory after run 126..130");

        // Range rejections
        rr0 = n_req_rise; wf0 = n_wframes;
        run(256, 1, -1, gd, ge, b1);
        check(ge && !gd && !b1, "R1", "offset at word size rejected", int'({ge, gd, b1}), 4);
        run(10, 0, -1, gd, ge, b1);
        check(ge && !gd && !b1, "R1", "zero count rejected", int'({ge, gd, b1}), 4);
        run(250, 7, -1, gd, ge, b1);
        check(ge && !gd && !b1, "R1", "count past end rejected", int'({ge, gd, b1}), 4);
        check(n_req_rise == rr0 && n_wframes == wf0, "R1", "no request on reject",
              n_req_rise - rr0, 0);

        // Exact fit up to the last word
        a80 = n_a8; wf0 = n_wframes;
        run(250, 6, -1, gd, ge, b1);
        expect_words(250, 6);
        check(gd && !ge, "R1", "run ending on last word accepted", int'({gd, ge}), 2);
        check(n_wframes - wf0 == 2 && n_a8 - a80 == 2, "R6", "frames for run 250..255",
              n_wframes - wf0, 2);
        compare_mem("R8", "memory after run 250..255");

        // Grant never arrives
        gnt_never = 1;
        wf0 = n_wframes; st0 = n_status;
        run(0, 2, -1, gd, ge, b1);
        check(ge && !gd, "R3", "grant timeout error", int'({ge, gd}), 2);
        check(!req_o && spi_cs_n_o && n_status == st0, "R3", "request dropped, no frames",
              int'({req_o, spi_cs_n_o}), 1);
        gnt_never = 0;

        // Device never ready
        busy_forever = 1;
        st0 = n_status;
        run(20, 3, -1, gd, ge, b1);
        check(ge && !gd, "R4", "ready timeout error", int'({ge, gd}), 2);
        check(n_status - st0 == READY_TRIES, "R4", "status frames before giving up",
              n_status - st0, READY_TRIES);
        check(!req_o && spi_cs_n_o && n_wframes == wf0, "R4", "released after ready timeout",
              int'({req_o, spi_cs_n_o}), 1);
        busy_forever = 0;
        compare_mem("R8", "memory unchanged by aborted runs");

        // Single last word
        a80 = n_a8;
        run(255, 1, -1, gd, ge, b1);
        expect_words(255, 1);
        check(gd && !ge && (n_a8 - a80 == 1), "R11", "done for single last word",
              int'({gd, ge}), 2);
        compare_mem("R8", "final memory image");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule